// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block checks a small set of on-chip memories when a fixed eight-byte command arrives on its byte input. It holds four RAMs and five ROMs as small internal arrays. Each RAM receives an address-dependent pattern and then its complement, and both are read back. Each ROM is summed over all of its words, and the sum is compared with a signature parameter. A shared read multiplexer that picks one RAM by index is checked last. The sequencer then publishes a 16-bit status word with one pass bit per check and a finished flag.

The status word becomes valid a fixed number of cycles after the command, whatever the memory sizes are. Software waits that long and then reads the word. The RAM checks destroy what the RAMs held before. While a run is in progress, the status word reads zero. A second command that arrives during a run has no effect.

Top module: `memtest_seq`

## Requirements
- R1: After reset, `status` reads 0x0000.
- R2: A run starts on the edge that accepts the eighth byte of the frame 0x4D, 0xEA, 0x6D, 0x54, 0x00, 0x00, 0x00, 0x00. A byte counts only when `cmd_valid` is high, and idle cycles between bytes are allowed.
- R3: A frame with any byte wrong starts no run. When a byte breaks the frame, a 0x4D in that byte counts as the first byte of a new frame.
- R4: From the start edge until the finish, `status` reads 0x0000. A new start clears a previous result.
- R5: Bit 15 (finished) rises exactly `LATENCY` cycles after the start edge (default 1,100,000), never earlier.
- R6: Bits 14:10 are always zero. A fully passing run reads 0x83FF.
- R7: ROM k (k = 0..4) holds word (a*(2k+3) + 165*k) mod 2^DW at address a. Its good bit is bit k, and it is set only when the sum of all its words mod 2^DW equals `ROM_SIG[k*DW +: DW]`. A wrong signature clears only that bit.
- R8: A complete start frame received during a run is ignored, and the finish time stays that of the first frame.
- R9: After the finish, `status` holds until the next start. A repeated run gives the same result.
- R10: RAM m (m = 0..3) has its good bit at bit 5+m. The bit is set only when the pattern and its complement both read back correctly at every address. Bit 9 is set only when the shared read multiplexer returns each RAM's own word at address 0. Both tests overwrite the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | `cmd_byte` is valid this cycle |
| cmd_byte | input | 8 | Command byte |
| status | output | 16 | Result word: 0 while running, else finished flag and pass bits |

## Verification
A corrupted frame-matcher index shows up as a run that starts on the wrong byte or never starts. In either case the finished flag appears at a cycle other than start plus `LATENCY`, or does not appear at all. A stuck compare or accumulator shows only at the finish, as a wrong pass bit. A wrong cycle counter moves the finish edge by one or more cycles, and the bench catches this because it checks the status one cycle before and exactly at the expected finish. A start that is not gated by the busy state restarts the count and moves the finish later.

// File: rtl/memtest_seq.sv
module memtest_seq #(
  parameter int DW        = 16,
  parameter int RAM_DEPTH = 16,
  parameter int ROM_DEPTH = 16,
  parameter int LATENCY   = 1100000,
  parameter logic [5*DW-1:0] ROM_SIG = {
    DW'(11*ROM_DEPTH*(ROM_DEPTH-1)/2 + 660*ROM_DEPTH),
    DW'(9*ROM_DEPTH*(ROM_DEPTH-1)/2 + 495*ROM_DEPTH),
    DW'(7*ROM_DEPTH*(ROM_DEPTH-1)/2 + 330*ROM_DEPTH),
    DW'(5*ROM_DEPTH*(ROM_DEPTH-1)/2 + 165*ROM_DEPTH),
    DW'(3*ROM_DEPTH*(ROM_DEPTH-1)/2)}
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic [15:0] status
);
  localparam int NRAM = 4;
  localparam int NROM = 5;
  localparam int MAXD = (RAM_DEPTH > ROM_DEPTH) ? RAM_DEPTH : ROM_DEPTH;
  localparam int AW   = $clog2(MAXD + 1);
  localparam int RAW  = $clog2(RAM_DEPTH);
  localparam int CW   = $clog2(LATENCY + 1);

  typedef enum logic [2:0] {S_IDLE, S_W1, S_R1, S_W2, S_R2, S_ROM, S_MUX, S_WAIT} state_t;

  state_t          st;
  logic [2:0]      idx;
  logic [AW-1:0]   addr;
  logic [CW-1:0]   cnt;
  logic [NRAM-1:0] ram_ok;
  logic [NROM-1:0] rom_ok;
  logic            mux_ok, done;
  logic [DW-1:0]   acc [NROM];
  logic [DW-1:0]   ram [NRAM][RAM_DEPTH];

  function automatic logic [7:0] frame_byte(input logic [2:0] i);
    case (i)
      3'd0: return 8'h4D;
      3'd1: return 8'hEA;
      3'd2: return 8'h6D;
      3'd3: return 8'h54;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] pat(input int m, input int a);
    return DW'(a * 4951) ^ DW'((m + 1) * 3855);
  endfunction

  function automatic logic [DW-1:0] rom_word(input int k, input int a);
    return DW'(a * (2 * k + 3) + 165 * k);
  endfunction

  wire hit      = cmd_valid && (cmd_byte == frame_byte(idx));
  wire busy     = (st != S_IDLE);
  wire start    = hit && (idx == 3'd7) && !busy;
  wire ram_last = (addr == AW'(RAM_DEPTH - 1));
  wire rom_last = (addr == AW'(ROM_DEPTH - 1));
  wire [RAW-1:0] ra = addr[RAW-1:0];

  assign status = done ? {1'b1, 5'b0, mux_ok, ram_ok, rom_ok} : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (cmd_valid) begin
      if (hit) idx <= idx + 3'd1;
      else     idx <= (cmd_byte == 8'h4D) ? 3'd1 : 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_W1 || st == S_W2)
      for (int m = 0; m < NRAM; m++)
        ram[m][ra] <= (st == S_W1) ? pat(m, int'(addr)) : ~pat(m, int'(addr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      cnt    <= '0;
      ram_ok <= '0;
      rom_ok <= '0;
      mux_ok <= 1'b0;
      done   <= 1'b0;
      for (int k = 0; k < NROM; k++) acc[k] <= '0;
    end else if (start) begin
      st     <= S_W1;
      addr   <= '0;
      cnt    <= '0;
      ram_ok <= '1;
      rom_ok <= '1;
      mux_ok <= 1'b1;
      done   <= 1'b0;
      for (int k = 0; k < NROM; k++) acc[k] <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      case (st)
        S_W1, S_W2: begin
          addr <= ram_last ? '0 : addr + AW'(1);
          if (ram_last) st <= (st == S_W1) ? S_R1 : S_R2;
        end
        S_R1, S_R2: begin
          for (int m = 0; m < NRAM; m++)
            if (ram[m][ra] != ((st == S_R1) ? pat(m, int'(addr)) : ~pat(m, int'(addr))))
              ram_ok[m] <= 1'b0;
          addr <= ram_last ? '0 : addr + AW'(1);
          if (ram_last) st <= (st == S_R1) ? S_W2 : S_ROM;
        end
        S_ROM: begin
          for (int k = 0; k < NROM; k++) begin
            acc[k] <= acc[k] + rom_word(k, int'(addr));
            if (rom_last && (acc[k] + rom_word(k, int'(addr)) != ROM_SIG[k*DW +: DW]))
              rom_ok[k] <= 1'b0;
          end
          addr <= rom_last ? '0 : addr + AW'(1);
          if (rom_last) st <= S_MUX;
        end
        S_MUX: begin
          if (ram[addr[1:0]][0] != ~pat(int'(addr[1:0]), 0)) mux_ok <= 1'b0;
          addr <= addr + AW'(1);
          if (addr[1:0] == 2'd3) st <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt >= CW'(LATENCY - 1)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
  parameter int LATENCY = 1100000
)(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic [15:0] status
);
  logic [31:0] since;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (start) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since != 32'hFFFF_FFFF) begin
      since <= since + 32'd1;
    end
  end

  assert_finish_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[15]) |-> (seen && since == 32'(LATENCY)));

  assert_busy_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 16'h0000));

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (status == 16'h0000));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15] && !start) |=> $stable(status));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] |-> (status[14:10] == 5'b0));
endmodule

bind memtest_seq memtest_seq_chk #(.LATENCY(LATENCY)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .status(status));

// File: tb/memtest_seq_test.sv
module memtest_seq_test;
  localparam int L = 2000;
  localparam int D = 16;

  function automatic logic [15:0] sig(input int k);
    return 16'((2 * k + 3) * D * (D - 1) / 2 + 165 * k * D);
  endfunction

  localparam logic [79:0] BAD_SIG = {sig(4), sig(3), sig(2) ^ 16'h0001, sig(1), sig(0)};

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [7:0] cmd_byte = 0;
  logic [15:0] st_a, st_b;
  int cyc = 0, errors = 0, checks = 0, last_e = 0;

  int          qc[$];
  logic [15:0] qa[$], qb[$];
  string       qt[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  memtest_seq #(.RAM_DEPTH(D), .ROM_DEPTH(D), .LATENCY(L)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .status(st_a));
  memtest_seq #(.RAM_DEPTH(D), .ROM_DEPTH(D), .LATENCY(L), .ROM_SIG(BAD_SIG)) uut_sig (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .status(st_b));

  task automatic expect_at(input int c, input logic [15:0] a, input logic [15:0] b, input string t);
    qc.push_back(c); qa.push_back(a); qb.push_back(b); qt.push_back(t);
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = b;
    @(posedge clk);
    #1;
    last_e = cyc;
    cmd_valid = 0;
  endtask

  task automatic send_frame(input int gap);
    send(8'h4D, gap); send(8'hEA, gap); send(8'h6D, gap); send(8'h54, gap);
    for (int i = 0; i < 4; i++) send(8'h00, gap);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (qc.size() > 0 && qc[0] <= cyc) begin
      int c; logic [15:0] a, b; string t;
      c = qc.pop_front(); a = qa.pop_front(); b = qb.pop_front(); t = qt.pop_front();
      checks += 2;
      if (c < cyc) begin
        errors += 2;
        $display("FAIL %s: check for cycle %0d missed, now %0d", t, c, cyc);
      end else begin
        if (st_a !== a) begin
          errors++;
          $display("FAIL %s uut cycle %0d: got %h expected %h", t, cyc, st_a, a);
        end
        if (st_b !== b) begin
          errors++;
          $display("FAIL %s uut_sig cycle %0d: got %h expected %h", t, cyc, st_b, b);
        end
      end
    end
  end

  initial begin
    int e1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    expect_at(cyc + 1, 16'h0000, 16'h0000, "R1 reset");
    wait_until(cyc + 3);

    // R3: one wrong byte, no run
    send(8'h4D, 0); send(8'hEA, 0); send(8'h6D, 0); send(8'h55, 0);
    for (int i = 0; i < 4; i++) send(8'h00, 0);
    expect_at(last_e + L + 2, 16'h0000, 16'h0000, "R3 bad frame");
    wait_until(last_e + L + 3);

    // R2/R3: leading extra 0x4D, gaps between bytes
    send(8'h4D, 1);
    send_frame(2);
    e1 = last_e;
    expect_at(e1 + 1, 16'h0000, 16'h0000, "R4 running");
    wait_until(e1 + 50);
    send_frame(0);
    expect_at(e1 + L - 1, 16'h0000, 16'h0000, "R5 not early / R8");
    expect_at(e1 + L, 16'h83FF, 16'h83FB, "R2 R5 R6 R7 result");
    expect_at(e1 + L + 40, 16'h83FF, 16'h83FB, "R9 hold");
    wait_until(e1 + L + 41);

    send_frame(0);
    e1 = last_e;
    expect_at(e1 + 1, 16'h0000, 16'h0000, "R4 cleared by restart");
    expect_at(e1 + L / 2, 16'h0000, 16'h0000, "R4 mid run");
    expect_at(e1 + L, 16'h83FF, 16'h83FB, "R9 R10 rerun");
    wait_until(e1 + L + 2);

    if (qc.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", qc.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected end before cycle 100000");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule